// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital control for a 10-bit successive-approximation converter. A start request arrives from a software write strobe or a hardware trigger. The block clears its approximation register and then resolves the code one bit at a time, starting at the most significant bit. For each bit it places a trial code on the DAC output, waits one clock for the analog path to settle, and then reads a one-bit comparator. After the last bit it latches the result and raises a completion flag.

The approximation register is 16 bits wide. In MSB-first numbering the code sits in bit positions 6 to 15. In the conventional `[15:0]` view these are bits 9..0, and bits 15..10 always read zero. The DAC and comparator are outside the block. The comparator input is 1 when the DAC voltage is below the analog input.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it is released, `dac_code_o`, `result_o`, `done_o` and `busy_o` are all zero.
- R2: When the block is idle, a high level on `sw_start_i` or on `hw_trig_i` at a rising clock edge starts a conversion.
- R3: On the edge that accepts a start, `done_o` and the approximation register are cleared to 0 and `busy_o` rises. In the first busy cycle, `dac_code_o` reads 0x0000.
- R4: In the second busy cycle, `dac_code_o` reads 0x0200. This is the code MSB alone (MSB-first position 6, conventional bit 9).
- R5: Each code bit takes two cycles. The trial bit is set, and one cycle later `cmp_below_i` is sampled: a 1 keeps the bit and a 0 clears it. The bits are resolved in order from MSB to LSB, which gives 10 comparisons, so `busy_o` stays high for exactly 20 cycles.
- R6: `result_o` takes the register value that includes the tenth comparison, and bits 15..10 of `result_o` and `dac_code_o` are always 0. The comparator model gives threshold 0 for code 0 and (code - 0.5)·VREF/1024 for codes 1..1023. With that model, the result is the largest code whose threshold lies strictly below the input.
- R7: `done_o` rises on the same edge that latches the result and drops `busy_o`. It then holds until the next accepted start or a `flag_clr_i` pulse.
- R8: A trigger on either input while `busy_o` is high is ignored, including in the final busy cycle. The conversion neither restarts nor changes its result.
- R9: If `flag_clr_i` is high on the edge where the result latches, `done_o` still becomes 1.
- R10: `flag_clr_i` clears `done_o` only. `result_o` holds its value until the next result latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_start_i | input | 1 | Software start strobe |
| hw_trig_i | input | 1 | Hardware start trigger |
| flag_clr_i | input | 1 | Software clear of the completion flag |
| cmp_below_i | input | 1 | Comparator: 1 when the DAC voltage is below the input |
| dac_code_o | output | 16 | Approximation register, drives the DAC |
| result_o | output | 16 | Latched conversion result |
| done_o | output | 1 | Conversion complete flag |
| busy_o | output | 1 | Conversion in progress |

## Verification
The completion flag can be set by the finishing comparison and cleared by software on the same edge. The bench raises `flag_clr_i` during the twentieth busy cycle, so the clear is sampled on the latching edge. It then expects `done_o` high one cycle later, with the scoreboarded result intact.

A second pairing places a start strobe on that same final busy edge. The bench expects the strobe to be dropped: the busy count stays at 20 and no extra result arrives. A separate clear issued while idle must drop the flag and leave `result_o` untouched.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int SAR_RES_W = 10;
  localparam int SAR_REG_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SET  = 2'd1,
    ST_CMP  = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_trigger.sv
module sar_trigger (
  input  logic sw_i,
  input  logic hw_i,
  input  logic idle_i,
  output logic start_acc_o
);
  logic req;
  assign req         = sw_i | hw_i;
  assign start_acc_o = req & idle_i;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int RES_W = SAR_RES_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_acc_i,
  output logic             busy_o,
  output logic             clr_o,
  output logic             set_o,
  output logic             cmp_en_o,
  output logic             fin_o,
  output logic [RES_W-1:0] bit_sel_o
);
  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(RES_W - 1);

  sar_state_e       state_q;
  logic [IDX_W-1:0] idx_q;

  assign busy_o   = (state_q != ST_IDLE);
  assign clr_o    = start_acc_i;
  assign set_o    = (state_q == ST_SET);
  assign cmp_en_o = (state_q == ST_CMP);
  assign fin_o    = cmp_en_o && (idx_q == LAST);

  // idx 0 selects the code MSB
  for (genvar g = 0; g < RES_W; g++) begin : g_sel
    assign bit_sel_o[g] = (idx_q == IDX_W'(RES_W - 1 - g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_acc_i) begin
          state_q <= ST_SET;
          idx_q   <= '0;
        end
        ST_SET:  state_q <= ST_CMP;
        ST_CMP: begin
          if (idx_q == LAST) begin
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_SET;
            idx_q   <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_bit_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMP && idx_q != LAST) |=> (state_q == ST_SET && idx_q == $past(idx_q) + 1'b1));

  assert_set_then_cmp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SET) |=> (state_q == ST_CMP));
endmodule

// File: rtl/sar_reg.sv
module sar_reg
  import sar_pkg::*;
#(
  parameter int RES_W = SAR_RES_W,
  parameter int REG_W = SAR_REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             set_i,
  input  logic             cmp_en_i,
  input  logic             fin_i,
  input  logic             start_acc_i,
  input  logic             flag_clr_i,
  input  logic             cmp_below_i,
  input  logic [RES_W-1:0] bit_sel_i,
  output logic [REG_W-1:0] sar_o,
  output logic [REG_W-1:0] result_o,
  output logic             done_o
);
  localparam int PAD_W = REG_W - RES_W;

  logic [RES_W-1:0] code_q, code_nxt, res_q;
  logic             done_q;

  always_comb begin
    code_nxt = code_q;
    if (clr_i)                        code_nxt = '0;
    else if (set_i)                   code_nxt = code_q | bit_sel_i;
    else if (cmp_en_i && !cmp_below_i) code_nxt = code_q & ~bit_sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      code_q <= code_nxt;
      if (fin_i) res_q <= code_nxt;
      // completion outranks a same-cycle clear
      if (fin_i)                          done_q <= 1'b1;
      else if (start_acc_i || flag_clr_i) done_q <= 1'b0;
    end
  end

  assign sar_o    = {{PAD_W{1'b0}}, code_q};
  assign result_o = {{PAD_W{1'b0}}, res_q};
  assign done_o   = done_q;

  assert_done_beats_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |=> done_o);

  assert_done_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_acc_i && !flag_clr_i) |=> done_o);

  assert_result_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fin_i |=> $stable(result_o));
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int RES_W = SAR_RES_W,
  parameter int REG_W = SAR_REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_start_i,
  input  logic             hw_trig_i,
  input  logic             flag_clr_i,
  input  logic             cmp_below_i,
  output logic [REG_W-1:0] dac_code_o,
  output logic [REG_W-1:0] result_o,
  output logic             done_o,
  output logic             busy_o
);
  localparam logic [REG_W-1:0] MSB_TRIAL = REG_W'(1) << (RES_W - 1);

  logic             start_acc, clr, set, cmp_en, fin;
  logic [RES_W-1:0] bit_sel;

  sar_trigger u_trig (
    .sw_i        (sw_start_i),
    .hw_i        (hw_trig_i),
    .idle_i      (!busy_o),
    .start_acc_o (start_acc)
  );

  sar_seq #(.RES_W(RES_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_acc_i (start_acc),
    .busy_o      (busy_o),
    .clr_o       (clr),
    .set_o       (set),
    .cmp_en_o    (cmp_en),
    .fin_o       (fin),
    .bit_sel_o   (bit_sel)
  );

  sar_reg #(.RES_W(RES_W), .REG_W(REG_W)) u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .set_i       (set),
    .cmp_en_i    (cmp_en),
    .fin_i       (fin),
    .start_acc_i (start_acc),
    .flag_clr_i  (flag_clr_i),
    .cmp_below_i (cmp_below_i),
    .bit_sel_i   (bit_sel),
    .sar_o       (dac_code_o),
    .result_o    (result_o),
    .done_o      (done_o)
  );

  assert_start_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (dac_code_o == '0 && !done_o));

  assert_first_trial_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> (dac_code_o == MSB_TRIAL));

  assert_pad_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dac_code_o >> RES_W) == '0) && ((result_o >> RES_W) == '0));
endmodule

// File: tb/sar_conv_ctrl_tb.sv
module sar_conv_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sw_start_i = 1'b0, hw_trig_i = 1'b0, flag_clr_i = 1'b0;
  logic        cmp_below_i;
  logic [15:0] dac_code_o, result_o;
  logic        done_o, busy_o;

  int vin2 = 0;  // input in units of VREF/2048
  int total = 0, bad = 0, cycles = 0;
  int exp_q[$];
  logic done_d = 1'b0;

  always #5 clk_i = ~clk_i;

  sar_conv_ctrl u_dut (
    .clk_i, .rst_ni, .sw_start_i, .hw_trig_i, .flag_clr_i, .cmp_below_i,
    .dac_code_o, .result_o, .done_o, .busy_o
  );

  // behavioural comparator with half-LSB offset thresholds
  assign cmp_below_i = (dac_code_o == 16'd0) ? (0 < vin2)
                                             : ((2 * int'(dac_code_o) - 1) < vin2);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // monitor: compare each new result with the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && done_o && !done_d) begin
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected result", int'(result_o), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(result_o == 16'(e), "R6 result", int'(result_o), e);
      end
    end
    done_d = done_o;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic convert(input int v, input bit use_hw, input int extra_at, input bit clr_end);
    int cnt, e;
    @(negedge clk_i);
    vin2 = v;
    e = (v / 2 > 1023) ? 1023 : v / 2;
    exp_q.push_back(e);
    if (use_hw) hw_trig_i = 1'b1; else sw_start_i = 1'b1;
    @(negedge clk_i);
    hw_trig_i = 1'b0; sw_start_i = 1'b0;
    chk(busy_o, "R2 start accepted", int'(busy_o), 1);
    chk(dac_code_o == 16'h0 && !done_o, "R3 clear at start", int'(dac_code_o), 0);
    cnt = 0;
    while (busy_o && cnt < 100) begin
      cnt++;
      if (cnt == 2) chk(dac_code_o == 16'h0200, "R4 first trial", int'(dac_code_o), 512);
      sw_start_i = (cnt == extra_at);
      flag_clr_i = clr_end && (cnt == 20);
      @(negedge clk_i);
    end
    sw_start_i = 1'b0; flag_clr_i = 1'b0;
    chk(cnt == 20, "R5 busy length", cnt, 20);
    chk(done_o, clr_end ? "R9 done beats clear" : "R7 done at latch", int'(done_o), 1);
    if (extra_at > 0) begin
      @(negedge clk_i);
      chk(!busy_o, "R8 trigger while busy ignored", int'(busy_o), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(dac_code_o == 0 && result_o == 0 && !done_o && !busy_o, "R1 reset state",
        int'(dac_code_o) + int'(result_o) + int'(done_o) + int'(busy_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(dac_code_o == 0 && result_o == 0 && !done_o && !busy_o, "R1 after release",
        int'(dac_code_o) + int'(result_o) + int'(done_o) + int'(busy_o), 0);

    convert(1500, 1'b0, 0, 1'b0);
    convert(0,    1'b1, 0, 1'b0);
    convert(1,    1'b0, 0, 1'b0);
    convert(2,    1'b1, 0, 1'b0);
    convert(3,    1'b0, 0, 1'b0);
    convert(1023, 1'b0, 7, 1'b0);   // R8 mid-conversion strobe
    convert(1024, 1'b1, 0, 1'b1);   // R9 clear on latch edge
    convert(2046, 1'b0, 20, 1'b0);  // R8 strobe on final busy edge
    convert(2047, 1'b1, 0, 1'b0);
    convert(2100, 1'b0, 0, 1'b0);   // clipped to 1023
    convert(777,  1'b1, 0, 1'b0);

    repeat (3) @(negedge clk_i);
    chk(done_o, "R7 done holds", int'(done_o), 1);
    chk(result_o == 16'd388, "R10 result before clear", int'(result_o), 388);
    flag_clr_i = 1'b1;
    @(negedge clk_i);
    flag_clr_i = 1'b0;
    chk(!done_o, "R10 clear drops done", int'(done_o), 0);
    chk(result_o == 16'd388, "R10 result kept", int'(result_o), 388);
    chk(dac_code_o[15:10] == 0, "R6 upper bits zero", int'(dac_code_o[15:10]), 0);
    chk(exp_q.size() == 0, "R6 all results seen", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule